// File: doc/BRIEF.md
# Framebuffer SRAM Access Arbiter

This block shares one single-port asynchronous SRAM between two clients. One is a display refresh reader that streams pixels out of the framebuffer. The other is a CPU-side pixel writer. Both clients hold a request until the arbiter acknowledges it. The arbiter then drives the SRAM address bus, the write-data bus with its output-enable, and the active-low chip, write and output enables.

A write always wins over a pending display read, and a read that has not yet been committed gives way to a write that arrives in the middle of it. Each write is a fixed two-cycle sequence. The address and data are captured when the write is accepted and do not change while the write-enable pulse is active, so a pixel always lands at the address it was requested for. A display-enable input shuts off all refresh reads, which leaves the memory to the writer alone.

The read pipeline presents the address in one cycle and captures the data in the next. The data is returned one cycle later with a valid strobe and the address it came from. The CPU port synchronizer and the video timing generator sit outside this block.

Top module: `fb_sram_arbiter`

## Requirements
- R1: When a write request and a display read request are both pending and the arbiter is idle, the write sequence starts on the next clock edge and the read waits.
- R2: A write occupies exactly two cycles. Write enable is low in the first cycle only. Address, write data and bus drive are identical in both cycles. `wr_ack_o` is high in the second cycle only.
- R3: The address and data of a write are captured when the request is accepted, and the SRAM location at that address holds that data afterwards, whatever reads run concurrently.
- R4: Each accepted write request produces exactly one write-enable cycle and exactly one `wr_ack_o` cycle. The requester holds `wr_req_i` until the acknowledge and may then drop it or present the next write.
- R5: `sram_dq_oe_o` is high only in write cycles, and `sram_oe_no` is high whenever the bus is driven.
- R6: The cycle after the second write cycle is a turnaround cycle in which no read is issued (`sram_oe_no` high, bus not driven).
- R7: A read drives `sram_oe_no` low with the requested address for two cycles, raises `rd_ack_o` in the second, and pulses `rd_valid_o` for one cycle in the following cycle with `rd_addr_o` and the SRAM data at that address.
- R8: A read whose first cycle is interrupted by a write request is abandoned without `rd_ack_o` or `rd_valid_o`, and is issued again after the write. `rd_valid_o` pulses only for reads that were acknowledged.
- R9: While `disp_en_i` is low, no new read is started: `sram_oe_no` stays high and `rd_valid_o` stays low, and writes still complete.
- R10: During reset, all three SRAM enables are high, the bus is not driven, and `wr_ack_o`, `rd_ack_o` and `rd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| disp_en_i | input | 1 | Enables refresh reads when high |
| wr_req_i | input | 1 | Pixel write request, held until acknowledged |
| wr_addr_i | input | ADDR_W | Pixel write address |
| wr_data_i | input | DATA_W | Pixel write data |
| wr_ack_o | output | 1 | Write completion pulse (second write cycle) |
| rd_req_i | input | 1 | Refresh read request, held until acknowledged |
| rd_addr_i | input | ADDR_W | Refresh read address |
| rd_ack_o | output | 1 | Read committed (second read cycle) |
| rd_valid_o | output | 1 | Read data valid strobe |
| rd_addr_o | output | ADDR_W | Address of the returned read data |
| rd_data_o | output | DATA_W | Returned read data |
| sram_addr_o | output | ADDR_W | SRAM address bus |
| sram_dq_o | output | DATA_W | SRAM write data |
| sram_dq_oe_o | output | 1 | Drive enable for the SRAM data bus |
| sram_dq_i | input | DATA_W | SRAM read data |
| sram_ce_no | output | 1 | SRAM chip enable, active low |
| sram_we_no | output | 1 | SRAM write enable, active low |
| sram_oe_no | output | 1 | SRAM output enable, active low |

## Verification
The bench targets the case of a write and a read arriving together. A design that favoured the read, or let the two overlap, would show a read cycle or bus contention where the write pulse belongs. It also places a write on the first cycle of a pending read to the same address. An arbiter that dropped the interrupted read would never return it, and one that kept the stale capture would return the old pixel instead of the new one. Random writes are injected into a streaming read pass and the final SRAM image is compared word by word. This exposes writes that were redirected or duplicated, or whose address moved while write enable was low. A window with the display disabled shows any read that leaks through.

// File: rtl/fb_arb_pkg.sv
package fb_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WR1  = 3'd1,
    ST_WR2  = 3'd2,
    ST_RD1  = 3'd3,
    ST_RD2  = 3'd4,
    ST_TURN = 3'd5
  } arb_state_e;
endpackage

// File: rtl/fb_arb_fsm.sv
module fb_arb_fsm
  import fb_arb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_req_i,
  input  logic       rd_req_i,
  input  logic       disp_en_i,
  output arb_state_e state_o,
  output logic       wr_accept_o,
  output logic       rd_accept_o
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_req_i)                    state_d = ST_WR1;
        else if (rd_req_i && disp_en_i)  state_d = ST_RD1;
      end
      ST_WR1:  state_d = ST_WR2;
      // the acknowledged request is still visible here, never re-accept it
      ST_WR2:  state_d = ST_TURN;
      ST_TURN: state_d = wr_req_i ? ST_WR1 : ST_IDLE;
      ST_RD1: begin
        if (wr_req_i)        state_d = ST_WR1;   // pre-empt, read stays pending
        else if (!disp_en_i) state_d = ST_IDLE;
        else                 state_d = ST_RD2;
      end
      ST_RD2:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign wr_accept_o = (state_d == ST_WR1);
  assign rd_accept_o = (state_d == ST_RD1);
endmodule

// File: rtl/fb_arb_wr_path.sv
module fb_arb_wr_path #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept_i) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/fb_arb_rd_path.sv
module fb_arb_rd_path #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic [DATA_W-1:0] ret_data_o
);
  logic [ADDR_W-1:0] req_addr_q, ret_addr_q;
  logic [DATA_W-1:0] ret_data_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_addr_q <= '0;
      ret_addr_q <= '0;
      ret_data_q <= '0;
      valid_q    <= 1'b0;
    end else begin
      if (accept_i) req_addr_q <= addr_i;
      valid_q <= capture_i;
      if (capture_i) begin
        ret_addr_q <= req_addr_q;
        ret_data_q <= sram_dq_i;
      end
    end
  end

  assign req_addr_o = req_addr_q;
  assign valid_o    = valid_q;
  assign ret_addr_o = ret_addr_q;
  assign ret_data_o = ret_data_q;
endmodule

// File: rtl/fb_sram_arbiter.sv
module fb_sram_arbiter
  import fb_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_en_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ack_o,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_ack_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              sram_oe_no
);
  arb_state_e        state;
  logic              wr_accept, rd_accept;
  logic [ADDR_W-1:0] wr_addr_q, rd_req_addr;
  logic [DATA_W-1:0] wr_data_q;
  logic              in_wr, in_rd;

  fb_arb_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_req_i    (wr_req_i),
    .rd_req_i    (rd_req_i),
    .disp_en_i   (disp_en_i),
    .state_o     (state),
    .wr_accept_o (wr_accept),
    .rd_accept_o (rd_accept)
  );

  fb_arb_wr_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (wr_accept),
    .addr_i   (wr_addr_i),
    .data_i   (wr_data_i),
    .addr_o   (wr_addr_q),
    .data_o   (wr_data_q)
  );

  fb_arb_rd_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (rd_accept),
    .capture_i  (state == ST_RD2),
    .addr_i     (rd_addr_i),
    .sram_dq_i  (sram_dq_i),
    .req_addr_o (rd_req_addr),
    .valid_o    (rd_valid_o),
    .ret_addr_o (rd_addr_o),
    .ret_data_o (rd_data_o)
  );

  assign in_wr = (state == ST_WR1) || (state == ST_WR2);
  assign in_rd = (state == ST_RD1) || (state == ST_RD2);

  assign sram_addr_o  = in_wr ? wr_addr_q : rd_req_addr;
  assign sram_dq_o    = wr_data_q;
  assign sram_dq_oe_o = in_wr;
  assign sram_ce_no   = !(in_wr || in_rd);
  assign sram_we_no   = !(state == ST_WR1);
  assign sram_oe_no   = !in_rd;
  assign wr_ack_o     = (state == ST_WR2);
  assign rd_ack_o     = (state == ST_RD2);
endmodule

// File: rtl/fb_sram_arbiter_chk.sv
module fb_sram_arbiter_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              disp_en_i,
  input logic              wr_ack_o,
  input logic              rd_ack_o,
  input logic              rd_valid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe_o,
  input logic              sram_ce_no,
  input logic              sram_we_no,
  input logic              sram_oe_no
);
  assert_we_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |=> sram_we_no && sram_dq_oe_o && $stable(sram_addr_o) && $stable(sram_dq_o));

  assert_ack_after_we_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_o |-> $past(!sram_we_no));

  assert_single_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_o |=> !wr_ack_o);

  assert_drive_no_oe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no && !sram_ce_no);

  assert_turnaround_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_dq_oe_o) |-> sram_oe_no);

  assert_valid_after_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_ack_o) && $past(!sram_oe_no));

  assert_ack_needs_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_o |-> $past(!sram_oe_no) && !sram_oe_no);

  assert_disp_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!disp_en_i && $past(!disp_en_i)) |-> sram_oe_no);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R10: assert (sram_ce_no && sram_we_no && sram_oe_no && !sram_dq_oe_o
                                     && !wr_ack_o && !rd_ack_o && !rd_valid_o);
    end
  end
endmodule

bind fb_sram_arbiter fb_sram_arbiter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .disp_en_i    (disp_en_i),
  .wr_ack_o     (wr_ack_o),
  .rd_ack_o     (rd_ack_o),
  .rd_valid_o   (rd_valid_o),
  .sram_addr_o  (sram_addr_o),
  .sram_dq_o    (sram_dq_o),
  .sram_dq_oe_o (sram_dq_oe_o),
  .sram_ce_no   (sram_ce_no),
  .sram_we_no   (sram_we_no),
  .sram_oe_no   (sram_oe_no)
);

// File: tb/fb_sram_arbiter_tb.sv
module fb_sram_arbiter_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam int AW = 5;
  localparam int DW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          disp_en_i = 1'b0;
  logic          wr_req_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic          wr_ack_o;
  logic          rd_req_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0;
  logic          rd_ack_o, rd_valid_o;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] rd_data_o;
  logic [AW-1:0] sram_addr_o;
  logic [DW-1:0] sram_dq_o, sram_dq_i;
  logic          sram_dq_oe_o, sram_ce_no, sram_we_no, sram_oe_no;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fb_sram_arbiter #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .disp_en_i(disp_en_i),
    .wr_req_i(wr_req_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .wr_ack_o(wr_ack_o),
    .rd_req_i(rd_req_i), .rd_addr_i(rd_addr_i), .rd_ack_o(rd_ack_o),
    .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o), .rd_data_o(rd_data_o),
    .sram_addr_o(sram_addr_o), .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe_o),
    .sram_dq_i(sram_dq_i), .sram_ce_no(sram_ce_no), .sram_we_no(sram_we_no),
    .sram_oe_no(sram_oe_no)
  );

  // behavioural async SRAM: latch on the rising edge of write enable
  logic [DW-1:0] mem    [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  int model_wr = 0;
  always @(posedge sram_we_no) begin
    if (rst_ni && !sram_ce_no) begin
      mem[sram_addr_o] <= sram_dq_o;
      model_wr++;
    end
  end
  assign sram_dq_i = (!sram_ce_no && !sram_oe_no) ? mem[sram_addr_o] : '0;

  int checks = 0, errors = 0;
  int n_wr = 0, n_we = 0, n_ack = 0, n_rd_checked = 0;
  int win_oe = 0, win_valid = 0;
  bit in_window = 1'b0;
  bit done = 1'b0;
  int exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] img_a(input int a);
    return DW'((a * 5 + 3) % (1 << DW));
  endfunction

  task automatic do_write(input int a, input int d);
    wr_addr_i = AW'(a);
    wr_data_i = DW'(d);
    wr_req_i  = 1'b1;
    do @(negedge clk_i); while (!wr_ack_o);
    shadow[a] = DW'(d);
    n_wr++;
    wr_req_i = 1'b0;
  endtask

  // monitor: counts and return-path checks (R4, R7, R8, R9)
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (!sram_we_no) n_we++;
      if (wr_ack_o) n_ack++;
      if (in_window && !sram_oe_no) win_oe++;
      if (in_window && rd_valid_o) win_valid++;
      if (rd_valid_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 valid without acknowledged read", 1, 0);
        end else begin
          int ea;
          ea = exp_q.pop_front();
          chk(rd_addr_o == AW'(ea), "R7 read address", int'(rd_addr_o), ea);
          chk(rd_data_o == shadow[ea], "R7 read data", int'(rd_data_o), int'(shadow[ea]));
          n_rd_checked++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = '0;
      shadow[i] = '0;
    end
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(sram_ce_no && sram_we_no && sram_oe_no, "R10 enables high in reset",
        {sram_ce_no, sram_we_no, sram_oe_no}, 7);
    chk(!sram_dq_oe_o && !wr_ack_o && !rd_ack_o && !rd_valid_o, "R10 idle outputs in reset",
        {sram_dq_oe_o, wr_ack_o, rd_ack_o, rd_valid_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // fill the image with the display off
    for (int a = 0; a < DEPTH; a++) do_write(a, int'(img_a(a)));
    repeat (2) @(negedge clk_i);

    // R1/R2/R6/R7: simultaneous requests, read of the address being written
    disp_en_i = 1'b1;
    wr_addr_i = AW'(9); wr_data_i = DW'(4'hA); wr_req_i = 1'b1;
    rd_addr_i = AW'(9); rd_req_i = 1'b1;
    @(negedge clk_i);
    chk(!sram_we_no && sram_oe_no, "R1 write first", {sram_we_no, sram_oe_no}, 1);
    chk(sram_addr_o == AW'(9) && sram_dq_o == DW'(4'hA) && sram_dq_oe_o, "R2 first write cycle",
        int'(sram_addr_o), 9);
    chk(!wr_ack_o, "R2 no ack in first cycle", wr_ack_o, 0);
    @(negedge clk_i);
    chk(sram_we_no && wr_ack_o && sram_dq_oe_o, "R2 second write cycle",
        {sram_we_no, wr_ack_o, sram_dq_oe_o}, 7);
    chk(sram_addr_o == AW'(9) && sram_dq_o == DW'(4'hA), "R2 held address and data",
        int'(sram_dq_o), 10);
    shadow[9] = DW'(4'hA); n_wr++;
    wr_req_i = 1'b0;
    @(negedge clk_i);
    chk(sram_oe_no && !sram_dq_oe_o && !wr_ack_o, "R6 turnaround",
        {sram_oe_no, sram_dq_oe_o, wr_ack_o}, 4);
    @(negedge clk_i);  // idle
    @(negedge clk_i);
    chk(!sram_oe_no && sram_addr_o == AW'(9) && !rd_ack_o, "R7 first read cycle",
        int'(sram_addr_o), 9);
    @(negedge clk_i);
    chk(!sram_oe_no && rd_ack_o, "R7 second read cycle", rd_ack_o, 1);
    exp_q.push_back(9);
    rd_req_i = 1'b0;
    @(negedge clk_i);
    chk(rd_valid_o && rd_data_o == DW'(4'hA), "R7 valid with new data", int'(rd_data_o), 10);
    @(negedge clk_i);
    chk(!rd_valid_o, "R7 single valid pulse", rd_valid_o, 0);

    // R8: write lands on the first cycle of a pending read
    rd_addr_i = AW'(20); rd_req_i = 1'b1;
    @(negedge clk_i);
    chk(!sram_oe_no && !rd_ack_o, "R8 read started", sram_oe_no, 0);
    wr_addr_i = AW'(20); wr_data_i = DW'(4'h6); wr_req_i = 1'b1;
    @(negedge clk_i);
    chk(!sram_we_no && !rd_ack_o, "R8 read pre-empted", {sram_we_no, rd_ack_o}, 0);
    @(negedge clk_i);
    chk(wr_ack_o, "R4 ack after pre-emption", wr_ack_o, 1);
    shadow[20] = DW'(4'h6); n_wr++;
    wr_req_i = 1'b0;
    do @(negedge clk_i); while (!rd_ack_o);
    exp_q.push_back(20);
    rd_req_i = 1'b0;
    @(negedge clk_i);
    chk(rd_valid_o && rd_addr_o == AW'(20) && rd_data_o == DW'(4'h6), "R8 retried read",
        int'(rd_data_o), 6);

    // streaming reads with writes injected on random cycles (R3)
    fork
      begin
        for (int i = 0; i < 2 * DEPTH; i++) begin
          rd_addr_i = AW'(i % DEPTH);
          rd_req_i = 1'b1;
          do @(negedge clk_i); while (!rd_ack_o);
          exp_q.push_back(i % DEPTH);
        end
        rd_req_i = 1'b0;
      end
      begin
        for (int k = 0; k < 40; k++) begin
          repeat ($urandom_range(0, 6)) @(negedge clk_i);
          do_write(int'($urandom_range(0, DEPTH - 1)), int'($urandom_range(0, (1 << DW) - 1)));
        end
      end
    join
    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R7 every acknowledged read returned", exp_q.size(), 0);
    chk(n_rd_checked == 2 * DEPTH + 2, "R8 no extra or missing valids", n_rd_checked, 2 * DEPTH + 2);

    // R9: display off, read held, a write still completes
    disp_en_i = 1'b0;
    @(negedge clk_i);
    in_window = 1'b1;
    rd_addr_i = AW'(3); rd_req_i = 1'b1;
    repeat (10) @(negedge clk_i);
    do_write(3, 5);
    repeat (20) @(negedge clk_i);
    in_window = 1'b0;
    rd_req_i = 1'b0;
    chk(win_oe == 0, "R9 no read while display off", win_oe, 0);
    chk(win_valid == 0, "R9 no valid while display off", win_valid, 0);
    repeat (3) @(negedge clk_i);

    // R3 final image, R4 counts
    for (int a = 0; a < DEPTH; a++)
      chk(mem[a] == shadow[a], "R3 final image", int'(mem[a]), int'(shadow[a]));
    chk(model_wr == n_wr, "R4 one SRAM write per request", model_wr, n_wr);
    chk(n_we == n_wr, "R4 one write-enable cycle per request", n_we, n_wr);
    chk(n_ack == n_wr, "R4 one ack per request", n_ack, n_wr);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule